// File: doc/BRIEF.md
# Software-Generated Interrupt Source Tracker

This block holds the pending state of the sixteen software-generated interrupts (IDs 0 to 15) for up to eight CPUs. Each combination of target CPU and interrupt ID keeps a pending flag and a bitmap with one bit per source CPU. The bitmap records which CPUs have asked for that interrupt on that target. A generation request names an ID, a source CPU and a mask of target CPUs. It marks the interrupt pending on every target in the mask and records the source in each of those targets' bitmaps.

When a CPU acknowledges one of these IDs, the block consumes the lowest-numbered source in its bitmap. The response carries the ID together with the number of that source. The pending flag stays set until the last recorded source has been consumed. Two byte-wide register windows, one for setting and one for clearing, let software read a bitmap and change it directly. A legacy build parameter turns both windows off. The pending flags go out to a separate priority selector.

Top module: `sgi_src_tracker`

## Requirements
- R1: After reset every pending flag and every source bitmap is zero, and `ack_done_o`, `ack_err_o` and `reg_bad_o` are low.
- R2: A generation request (`gen_valid_i`) ORs source bit `gen_src_i` into the bitmap of ID `gen_id_i` on every CPU whose bit is set in `gen_tgt_i`, and sets those pending flags. CPUs outside the mask are untouched.
- R3: An acknowledge from CPU `ack_cpu_i` for ID `ack_id_i` with a non-empty bitmap removes the lowest set source bit. One cycle later `ack_done_o` pulses and `ack_data_o` holds the ID in bits 3:0 and the source number in bits 12:10, with all other bits zero.
- R4: After an acknowledge the pending flag stays set while the bitmap is non-zero, and it clears in the same update that empties the bitmap.
- R5: An acknowledge that finds an empty bitmap pulses `ack_err_o` with `ack_done_o` one cycle later, gives `ack_data_o` = 0, and leaves the flag and the bitmap unchanged.
- R6: A write to address 0xF10+ID clears, in the accessing CPU's bitmap, the bits set in the written byte. If the bitmap is then empty, the pending flag clears, even when the written byte is zero.
- R7: A write to address 0xF20+ID ORs the written byte into the accessing CPU's bitmap and sets the pending flag, even when the byte is zero.
- R8: A read of 0xF10+ID or 0xF20+ID returns on `reg_rdata_o`, one cycle later, the accessing CPU's bitmap as it stood before the access cycle. A read changes no state.
- R9: An access outside 0xF10 to 0xF2F, or any access when `LEGACY`=1, pulses `reg_bad_o` one cycle later, returns 0 on `reg_rdata_o` and changes no state.
- R10: Requests that arrive in the same cycle are applied in this order: generation first, then the register write, then the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_valid_i | input | 1 | Generation request strobe |
| gen_id_i | input | 4 | Interrupt ID to generate |
| gen_src_i | input | 3 | Requesting (source) CPU |
| gen_tgt_i | input | NUM_CPU | Target CPU mask |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_cpu_i | input | 3 | Acknowledging CPU |
| ack_id_i | input | 4 | Acknowledged interrupt ID |
| ack_done_o | output | 1 | Acknowledge response valid |
| ack_err_o | output | 1 | Acknowledge found an empty bitmap |
| ack_data_o | output | 13 | Source in bits 12:10, ID in bits 3:0 |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_cpu_i | input | 3 | Accessing CPU |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 8 | Write byte, one bit per source CPU |
| reg_rdata_o | output | 8 | Read byte |
| reg_bad_o | output | 1 | Invalid-register pulse |
| pend_o | output | NUM_CPU*16 | Pending flag of CPU c, ID i at bit c*16+i |

## Verification
The assertions assume that every CPU index presented on `gen_src_i`, `ack_cpu_i` and `reg_cpu_i` is below `NUM_CPU`. They also assume that the strobes are low during reset. The stimulus uses only CPU numbers 0 to 7 with the default eight CPUs and holds every strobe low until reset is released. It does not rely on any behaviour for an acknowledge of an unrecorded source, apart from the empty-bitmap error case stated in R5.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_NUM   = 16;
  localparam int ID_W      = 4;
  localparam int CPU_IDX_W = 3;
  localparam int ACK_W     = 13;
  localparam int SRC_LSB   = 10;
  localparam int ADDR_W    = 12;
  localparam logic [7:0] CLR_PAGE = 8'hF1;
  localparam logic [7:0] SET_PAGE = 8'hF2;
endpackage

// File: rtl/sgi_lsb_enc.sv
module sgi_lsb_enc #(
  parameter int W     = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int b = W - 1; b >= 0; b--) begin
      if (vec_i[b]) begin
        idx_o   = IDX_W'(b);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
  parameter int NUM_CPU = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gen_hit_i,
  input  logic [NUM_CPU-1:0] gen_src_oh_i,
  input  logic               set_hit_i,
  input  logic               clr_hit_i,
  input  logic [NUM_CPU-1:0] wdata_i,
  input  logic               ack_hit_i,
  output logic [NUM_CPU-1:0] map_o,
  output logic               pend_o,
  output logic [NUM_CPU-1:0] mid_map_o
);
  logic [NUM_CPU-1:0] map_q, map_d, mid_map;
  logic               pend_q, pend_d, pend_mid;

  // order: generation, register write, acknowledge
  always_comb begin
    mid_map  = map_q;
    pend_mid = pend_q;
    if (gen_hit_i) begin
      mid_map  = mid_map | gen_src_oh_i;
      pend_mid = 1'b1;
    end
    if (set_hit_i) begin
      mid_map  = mid_map | wdata_i;
      pend_mid = 1'b1;
    end
    if (clr_hit_i) begin
      mid_map = mid_map & ~wdata_i;
      if (mid_map == '0) pend_mid = 1'b0;
    end
    map_d  = mid_map;
    pend_d = pend_mid;
    if (ack_hit_i && (mid_map != '0)) begin
      map_d = mid_map & (mid_map - 1'b1);  // drop lowest source
      if (map_d == '0) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      pend_q <= pend_d;
    end
  end

  assign map_o     = map_q;
  assign pend_o    = pend_q;
  assign mid_map_o = mid_map;

  // R2 R7
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(gen_hit_i || set_hit_i));

  // R3
  ack_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit_i && (mid_map != '0)) |=> ($countones(map_q) == $countones($past(mid_map)) - 1));

  // R4
  pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> (map_q == '0));

  // R5
  ack_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit_i && (mid_map == '0)) |=> (map_q == '0));
endmodule

// File: rtl/sgi_src_tracker.sv
module sgi_src_tracker
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter bit LEGACY  = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       gen_valid_i,
  input  logic [ID_W-1:0]            gen_id_i,
  input  logic [CPU_IDX_W-1:0]       gen_src_i,
  input  logic [NUM_CPU-1:0]         gen_tgt_i,
  input  logic                       ack_valid_i,
  input  logic [CPU_IDX_W-1:0]       ack_cpu_i,
  input  logic [ID_W-1:0]            ack_id_i,
  output logic                       ack_done_o,
  output logic                       ack_err_o,
  output logic [ACK_W-1:0]           ack_data_o,
  input  logic                       reg_valid_i,
  input  logic                       reg_write_i,
  input  logic [CPU_IDX_W-1:0]       reg_cpu_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [7:0]                 reg_wdata_i,
  output logic [7:0]                 reg_rdata_o,
  output logic                       reg_bad_o,
  output logic [NUM_CPU*SGI_NUM-1:0] pend_o
);
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [NUM_CPU-1:0][SGI_NUM-1:0]              gen_hit, set_hit, clr_hit, ack_hit, pend_q;
  logic [NUM_CPU-1:0][SGI_NUM-1:0][NUM_CPU-1:0] map_q, mid_map;
  logic [NUM_CPU-1:0] gen_src_oh;
  logic               in_clr, in_set, win_ok, wr_ok;
  logic [ID_W-1:0]    win_id;

  assign in_clr = (reg_addr_i[ADDR_W-1:4] == CLR_PAGE);
  assign in_set = (reg_addr_i[ADDR_W-1:4] == SET_PAGE);
  assign win_ok = !LEGACY && (in_clr || in_set);
  assign wr_ok  = reg_valid_i && reg_write_i && win_ok;
  assign win_id = reg_addr_i[ID_W-1:0];

  always_comb begin
    gen_src_oh = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (gen_src_i == CPU_IDX_W'(c)) gen_src_oh[c] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < SGI_NUM; i++) begin : g_sgi
      assign gen_hit[c][i] = gen_valid_i && gen_tgt_i[c] && (gen_id_i == ID_W'(i));
      assign set_hit[c][i] = wr_ok && in_set && (reg_cpu_i == CPU_IDX_W'(c)) && (win_id == ID_W'(i));
      assign clr_hit[c][i] = wr_ok && in_clr && (reg_cpu_i == CPU_IDX_W'(c)) && (win_id == ID_W'(i));
      assign ack_hit[c][i] = ack_valid_i && (ack_cpu_i == CPU_IDX_W'(c)) && (ack_id_i == ID_W'(i));

      sgi_cell #(.NUM_CPU(NUM_CPU)) u_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .gen_hit_i   (gen_hit[c][i]),
        .gen_src_oh_i(gen_src_oh),
        .set_hit_i   (set_hit[c][i]),
        .clr_hit_i   (clr_hit[c][i]),
        .wdata_i     (reg_wdata_i[NUM_CPU-1:0]),
        .ack_hit_i   (ack_hit[c][i]),
        .map_o       (map_q[c][i]),
        .pend_o      (pend_q[c][i]),
        .mid_map_o   (mid_map[c][i])
      );
    end
  end

  assign pend_o = pend_q;

  // acknowledge response
  logic [NUM_CPU-1:0] ack_map;
  logic [IDX_W-1:0]   ack_src;
  logic               ack_found;
  logic [ACK_W-1:0]   ack_word;

  always_comb begin
    ack_map = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int i = 0; i < SGI_NUM; i++)
        if ((ack_cpu_i == CPU_IDX_W'(c)) && (ack_id_i == ID_W'(i))) ack_map = mid_map[c][i];
  end

  sgi_lsb_enc #(.W(NUM_CPU)) u_enc (
    .vec_i  (ack_map),
    .idx_o  (ack_src),
    .found_o(ack_found)
  );

  always_comb begin
    ack_word = '0;
    ack_word[ID_W-1:0] = ack_id_i;
    ack_word[SRC_LSB +: IDX_W] = ack_src;
  end

  // register read
  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int i = 0; i < SGI_NUM; i++)
        if ((reg_cpu_i == CPU_IDX_W'(c)) && (win_id == ID_W'(i))) rd_byte[NUM_CPU-1:0] = map_q[c][i];
    if (!win_ok) rd_byte = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_done_o  <= 1'b0;
      ack_err_o   <= 1'b0;
      ack_data_o  <= '0;
      reg_rdata_o <= '0;
      reg_bad_o   <= 1'b0;
    end else begin
      ack_done_o  <= ack_valid_i;
      ack_err_o   <= ack_valid_i && !ack_found;
      ack_data_o  <= (ack_valid_i && ack_found) ? ack_word : '0;
      reg_rdata_o <= (reg_valid_i && !reg_write_i) ? rd_byte : '0;
      reg_bad_o   <= reg_valid_i && !win_ok;
    end
  end

  // R9
  legacy_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEGACY && reg_valid_i) |=> reg_bad_o);

  // R3
  ack_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_done_o && !ack_err_o) |-> (ack_data_o[ID_W-1:0] == $past(ack_id_i)));

  // R5
  ack_err_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> (ack_data_o == '0));
endmodule

// File: tb/sgi_src_tracker_tb.sv
module sgi_src_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;

  localparam logic [2:0] K_GEN = 3'd0, K_ACK = 3'd1, K_RDS = 3'd2, K_SET = 3'd3,
                         K_CLR = 3'd4, K_PND = 3'd5, K_RDC = 3'd6;

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  cpu;
    logic [3:0]  id;
    logic [7:0]  data;
    logic [7:0]  tgt;
    logic [13:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{K_GEN, 3'd1, 4'd3,  8'd5,  8'h06, 14'h0001},
    '{K_GEN, 3'd1, 4'd3,  8'd2,  8'h02, 14'h0001},
    '{K_RDS, 3'd1, 4'd3,  8'd0,  8'h00, 14'h0024},
    '{K_RDS, 3'd2, 4'd3,  8'd0,  8'h00, 14'h0020},
    '{K_RDS, 3'd0, 4'd3,  8'd0,  8'h00, 14'h0000},
    '{K_ACK, 3'd1, 4'd3,  8'd0,  8'h00, 14'h0803},
    '{K_PND, 3'd1, 4'd3,  8'd0,  8'h00, 14'h0001},
    '{K_ACK, 3'd1, 4'd3,  8'd0,  8'h00, 14'h1403},
    '{K_PND, 3'd1, 4'd3,  8'd0,  8'h00, 14'h0000},
    '{K_ACK, 3'd1, 4'd3,  8'd0,  8'h00, 14'h2000},
    '{K_SET, 3'd4, 4'd15, 8'h81, 8'h00, 14'h0001},
    '{K_RDS, 3'd4, 4'd15, 8'd0,  8'h00, 14'h0081},
    '{K_CLR, 3'd4, 4'd15, 8'h01, 8'h00, 14'h0001},
    '{K_CLR, 3'd4, 4'd15, 8'h80, 8'h00, 14'h0000},
    '{K_SET, 3'd0, 4'd0,  8'h00, 8'h00, 14'h0001},
    '{K_ACK, 3'd0, 4'd0,  8'd0,  8'h00, 14'h2000},
    '{K_PND, 3'd0, 4'd0,  8'd0,  8'h00, 14'h0001},
    '{K_CLR, 3'd0, 4'd0,  8'h00, 8'h00, 14'h0000},
    '{K_GEN, 3'd7, 4'd7,  8'd7,  8'hFF, 14'h0001},
    '{K_ACK, 3'd7, 4'd7,  8'd0,  8'h00, 14'h1C07},
    '{K_ACK, 3'd0, 4'd7,  8'd0,  8'h00, 14'h1C07},
    '{K_RDC, 3'd3, 4'd7,  8'd0,  8'h00, 14'h0080}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic gen_valid = 0, ack_valid = 0, reg_valid = 0, reg_write = 0;
  logic [3:0] gen_id = 0, ack_id = 0;
  logic [2:0] gen_src = 0, ack_cpu = 0, reg_cpu = 0;
  logic [NC-1:0] gen_tgt = 0;
  logic [11:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;

  logic ack_done, ack_err, reg_bad, l_done, l_err, l_bad;
  logic [12:0] ack_data, l_data;
  logic [7:0] reg_rdata, l_rdata;
  logic [NC*16-1:0] pend, l_pend;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_src_tracker #(.NUM_CPU(NC), .LEGACY(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .gen_valid_i(gen_valid), .gen_id_i(gen_id), .gen_src_i(gen_src), .gen_tgt_i(gen_tgt),
    .ack_valid_i(ack_valid), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id),
    .ack_done_o(ack_done), .ack_err_o(ack_err), .ack_data_o(ack_data),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_cpu_i(reg_cpu),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .reg_bad_o(reg_bad), .pend_o(pend));

  sgi_src_tracker #(.NUM_CPU(NC), .LEGACY(1'b1)) u_legacy (
    .clk_i(clk), .rst_ni(rst_n),
    .gen_valid_i(gen_valid), .gen_id_i(gen_id), .gen_src_i(gen_src), .gen_tgt_i(gen_tgt),
    .ack_valid_i(ack_valid), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id),
    .ack_done_o(l_done), .ack_err_o(l_err), .ack_data_o(l_data),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_cpu_i(reg_cpu),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(l_rdata),
    .reg_bad_o(l_bad), .pend_o(l_pend));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    gen_valid = 0; ack_valid = 0; reg_valid = 0; reg_write = 0;
  endtask

  // inputs set at a negedge, held one cycle, outputs sampled at the following negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic drive_vec(input vec_t v);
    @(negedge clk);
    case (v.kind)
      K_GEN: begin gen_valid = 1; gen_id = v.id; gen_src = v.data[2:0]; gen_tgt = v.tgt; end
      K_ACK: begin ack_valid = 1; ack_cpu = v.cpu; ack_id = v.id; end
      K_RDS: begin reg_valid = 1; reg_write = 0; reg_cpu = v.cpu; reg_addr = {8'hF2, v.id}; end
      K_RDC: begin reg_valid = 1; reg_write = 0; reg_cpu = v.cpu; reg_addr = {8'hF1, v.id}; end
      K_SET: begin reg_valid = 1; reg_write = 1; reg_cpu = v.cpu; reg_addr = {8'hF2, v.id}; reg_wdata = v.data; end
      K_CLR: begin reg_valid = 1; reg_write = 1; reg_cpu = v.cpu; reg_addr = {8'hF1, v.id}; reg_wdata = v.data; end
      default: ;
    endcase
    step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pend", 32'(pend), 32'h0);
    check("R1 strobes", {29'd0, ack_done, ack_err, reg_bad}, 32'h0);
    rst_n = 1;
    step();
    check("R1 pend after release", 32'(pend >> 64), 32'h0);

    for (int k = 0; k < NV; k++) begin
      drive_vec(VEC[k]);
      case (VEC[k].kind)
        K_GEN: check("R2 gen pend", 32'(pend[VEC[k].cpu*16 + VEC[k].id]), 32'(VEC[k].exp));
        K_ACK: check("R3 R5 ack resp", {17'd0, ack_done, ack_err, ack_data}, {17'd0, 1'b1, VEC[k].exp});
        K_RDS, K_RDC: check("R8 read", 32'(reg_rdata), 32'(VEC[k].exp));
        K_SET: check("R7 set pend", 32'(pend[VEC[k].cpu*16 + VEC[k].id]), 32'(VEC[k].exp));
        K_CLR: check("R6 clr pend", 32'(pend[VEC[k].cpu*16 + VEC[k].id]), 32'(VEC[k].exp));
        default: check("R4 pend", 32'(pend[VEC[k].cpu*16 + VEC[k].id]), 32'(VEC[k].exp));
      endcase
    end

    // R2: non-target CPU 0 not pending for ID 3
    check("R2 non-target", 32'(pend[0*16+3]), 32'h0);

    // R10: generation and acknowledge in one cycle
    @(negedge clk);
    gen_valid = 1; gen_id = 4'd9; gen_src = 3'd6; gen_tgt = 8'h20;
    ack_valid = 1; ack_cpu = 3'd5; ack_id = 4'd9;
    step();
    check("R10 gen+ack data", {18'd0, ack_err, ack_data}, 32'h1809);
    check("R10 gen+ack pend", 32'(pend[5*16+9]), 32'h0);

    // R10: register set and acknowledge in one cycle
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_cpu = 3'd5; reg_addr = 12'hF2A; reg_wdata = 8'h08;
    ack_valid = 1; ack_cpu = 3'd5; ack_id = 4'd10;
    step();
    check("R10 set+ack data", {18'd0, ack_err, ack_data}, 32'h0C0A);
    check("R10 set+ack pend", 32'(pend[5*16+10]), 32'h0);

    // R9: addresses outside the windows
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_cpu = 3'd0; reg_addr = 12'hF30;
    step();
    check("R9 bad read", {23'd0, reg_bad, reg_rdata}, {23'd0, 1'b1, 8'h00});
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_cpu = 3'd0; reg_addr = 12'hF05; reg_wdata = 8'hFF;
    step();
    check("R9 bad write", 32'(reg_bad), 32'h1);
    check("R9 no pend", 32'(pend[0*16+5]), 32'h0);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_cpu = 3'd0; reg_addr = 12'hF25;
    step();
    check("R9 map untouched", {23'd0, reg_bad, reg_rdata}, 32'h0);

    // R9: legacy build rejects the windows
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_cpu = 3'd6; reg_addr = 12'hF2C; reg_wdata = 8'h01;
    step();
    check("R9 legacy bad", 32'(l_bad), 32'h1);
    check("R9 legacy no pend", 32'(l_pend[6*16+12]), 32'h0);
    check("R7 normal pend", 32'(pend[6*16+12]), 32'h1);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_cpu = 3'd6; reg_addr = 12'hF1C;
    step();
    check("R9 legacy read zero", 32'(l_rdata), 32'h0);
    check("R8 normal read clr window", 32'(reg_rdata), 32'h01);

    finish_run();
  end
endmodule